// File: doc/BRIEF.md
# Dual-Core Sampling Converter Serial Responder

This block is a synthesizable stand-in for the digital side of a dual-core, simultaneous-sampling 12-bit successive-approximation converter. It is used as a serial slave when testing masters. Each core has two selectable inputs. Analog conversion is replaced by four parallel sample ports that carry straight-binary codes, where one step equals the reference divided by 2^12. When the active-low chip-select falls, the block captures one 12-bit word per core. Both words are chosen by a registered channel selection. The two words are then shifted out together on two serial outputs. Each output is modelled as a data bit plus a shared drive-enable.

A fast system clock oversamples the serial clock, the chip-select and the channel select through synchronizers. The outputs change only in response to serial-clock falling edges or chip-select edges. Where the chip-select rises within a frame decides the power mode: normal, power-down, or waking. A frame that starts in power-down is a dummy frame that carries invalid data. Frames of 16 clocks release the outputs before the next frame starts. Frames of 14 clocks keep the outputs driven between frames.

Top module: `sar_link_responder`

## Requirements
- R1: After reset the mode output reads 2'b00 (normal), the drive-enable is low, both data outputs read 0, the abort counter is 0, and input 1 is selected for the first frame.
- R2: In a normal frame, the chip-select falling edge drives a 0 on both outputs with the drive-enable high. Serial falling edge k (k = 1..12) then drives bit 12-k of each core's captured word, MSB first. Falling edges 13 and 14 drive 0. Both cores shift in step.
- R3: The word captured at a chip-select falling edge comes from input 2 if the channel select was high at the serial falling edges numbered 2 to 12 of the previous frame, and from input 1 if it was low. A frame that ends before its 2nd falling edge leaves the selection unchanged.
- R4: The 15th serial falling edge of a frame drops the drive-enable. The outputs stay released, with the data at 0, until the next chip-select falling edge, whatever the serial clock does in the meantime.
- R5: If chip-select rises after 10 to 14 falling edges of a normal frame, the mode stays normal and the outputs keep driving the level of the last slot (14-clock framing).
- R6: If chip-select rises after 2 to 9 falling edges of a normal frame, the outputs are released at once, the mode becomes 2'b01 (power-down), and the abort counter increments by one.
- R7: If chip-select rises after 0 or 1 falling edge of a normal frame, the outputs are released, the mode does not change, and the abort counter increments by one.
- R8: A chip-select falling edge in power-down sets the mode to 2'b10 (waking). That frame is a dummy frame: both outputs drive 1 in every slot from the chip-select fall through falling edge 14.
- R9: A dummy frame that lasts at least 10 falling edges returns the mode to normal, and the next frame carries valid data. A shorter one releases the outputs and returns to power-down. Dummy frames never change the abort counter.
- R10: When a serial falling edge and the chip-select rise reach the block in the same system clock cycle, the edge is counted before the abort/keep decision. The 10th edge arriving together with the rise therefore keeps normal mode, and the 9th arriving together with the rise enters power-down.
- R11: The mode output never reads 2'b11, and the two cores' drive-enables are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the serial signals |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the master, idles high |
| cs_n | input | 1 | Active-low chip-select, frames a conversion |
| chan_sel | input | 1 | Channel select: 0 picks input 1, 1 picks input 2 |
| a_in1 | input | DATA_W | Core A sample, input 1 |
| a_in2 | input | DATA_W | Core A sample, input 2 |
| b_in1 | input | DATA_W | Core B sample, input 1 |
| b_in2 | input | DATA_W | Core B sample, input 2 |
| dout_a | output | 1 | Core A serial data (0 while released) |
| dout_b | output | 1 | Core B serial data (0 while released) |
| dout_en | output | 1 | Drive-enable of both serial outputs |
| mode_o | output | 2 | Mode: 00 normal, 01 power-down, 10 waking |
| abort_cnt_o | output | ABORT_W | Count of aborted normal frames |

## Verification
The critical collision is a serial falling edge and a chip-select rise that reach the block in the same system clock cycle. The same edge then both advances the slot counter and decides abort versus keep-normal at the 10-edge threshold. The bench provokes this by changing both lines in the same time step, once on the 10th edge and once on the 9th. It judges the result from the mode output, the abort counter, and whether the outputs stay driven with the bit of the 10th slot. Ordinary frames of 0, 1, 3, 5, 14 and 16 edges, plus dummy frames of 6, 10 and 12 edges, bound the neighbouring thresholds.

// File: rtl/sar_link_pkg.sv
// Shared types for the dual-core serial responder.
// Assumes: mode codes are visible on a port, so the encoding is fixed.
package sar_link_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_PD     = 2'b01,
        MODE_WAKE   = 2'b10
    } link_mode_e;
endpackage

// File: rtl/sar_edge_sync.sv
// Synchronizes a group of asynchronous single-bit inputs into clk and
// reports the level plus one-cycle rise and fall pulses per bit.
// Assumes: each input stays stable for several clk cycles between changes.
module sar_edge_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic              prev_q;

        // shift the raw input through the synchronizer chain
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[g]}};
                prev_q  <= RST_VAL[g];
            end else begin
                chain_q <= {chain_q[STAGES-2:0], raw_i[g]};
                prev_q  <= chain_q[STAGES-1];
            end
        end

        assign lvl_o[g]  = chain_q[STAGES-1];
        assign rise_o[g] = chain_q[STAGES-1] & ~prev_q;
        assign fall_o[g] = ~chain_q[STAGES-1] & prev_q;
    end
endmodule

// File: rtl/sar_frame_ctrl.sv
// Frame controller: counts serial falling edges inside a frame, keeps the
// registered channel choice, runs the normal / power-down / waking mode
// machine and counts aborted normal frames.
// Assumes: edge pulses come from sar_edge_sync; a chip-select fall never
// coincides with a serial falling edge.
module sar_frame_ctrl
    import sar_link_pkg::*;
#(
    parameter int DATA_W   = 12,
    parameter int TAIL_W   = 2,
    parameter int PD_MIN   = 2,
    parameter int KEEP_MIN = 10,
    parameter int ABORT_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_fall_i,
    input  logic               cs_rise_i,
    input  logic               sck_fall_i,
    input  logic               chsel_i,
    output logic               load_o,
    output logic               dummy_o,
    output logic               shift_o,
    output logic               kill_o,
    output logic               chan_o,
    output link_mode_e         mode_o,
    output logic [ABORT_W-1:0] abort_cnt_o
);
    localparam int SR_W  = DATA_W + 1 + TAIL_W;
    localparam int CNT_W = $clog2(SR_W + 1);
    localparam logic [CNT_W-1:0] CNT_MAX   = '1;
    localparam logic [CNT_W-1:0] PD_C      = CNT_W'(PD_MIN);
    localparam logic [CNT_W-1:0] KEEP_C    = CNT_W'(KEEP_MIN);
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(SR_W - 1);
    localparam logic [CNT_W-1:0] SEL_FIRST = CNT_W'(2);
    localparam logic [CNT_W-1:0] SEL_LAST  = CNT_W'(DATA_W);

    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   cnt_eff;
    logic               act_q;
    logic               chan_q;
    logic               end_frame;
    link_mode_e         mode_q;
    logic [ABORT_W-1:0] abort_q;

    // edges counted this cycle are included before any end-of-frame decision
    always_comb begin
        cnt_eff = cnt_q;
        if (shift_o && cnt_q != CNT_MAX) cnt_eff = cnt_q + CNT_W'(1);
    end

    assign load_o    = cs_fall_i;
    assign dummy_o   = (mode_q == MODE_PD);
    assign shift_o   = sck_fall_i && act_q;
    assign end_frame = cs_rise_i && act_q;
    assign kill_o    = (shift_o && cnt_q == LAST_SLOT) ||
                       (end_frame && cnt_eff < KEEP_C);
    assign chan_o    = chan_q;
    assign mode_o    = mode_q;
    assign abort_cnt_o = abort_q;

    // frame activity and saturating edge counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            cnt_q <= '0;
        end else if (cs_fall_i) begin
            act_q <= 1'b1;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_eff;
            if (end_frame) act_q <= 1'b0;
        end
    end

    // channel select is sampled on falling edges 2..DATA_W of each frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= 1'b0;
        end else if (shift_o && cnt_eff >= SEL_FIRST && cnt_eff <= SEL_LAST) begin
            chan_q <= chsel_i;
        end
    end

    // mode machine and abort counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_NORMAL;
            abort_q <= '0;
        end else if (cs_fall_i) begin
            if (mode_q == MODE_PD) mode_q <= MODE_WAKE;
        end else if (end_frame) begin
            case (mode_q)
                MODE_WAKE: mode_q <= (cnt_eff >= KEEP_C) ? MODE_NORMAL : MODE_PD;
                MODE_NORMAL: begin
                    if (cnt_eff < KEEP_C) begin
                        abort_q <= abort_q + ABORT_W'(1);
                        if (cnt_eff >= PD_C) mode_q <= MODE_PD;
                    end
                end
                default: mode_q <= mode_q;
            endcase
        end
    end

    // R11: mode code 2'b11 is never reached
    a_r11_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q != 2'b11);

    // R5: a normal frame ended at or past the keep threshold stays normal
    a_r5_keep_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (end_frame && mode_q == MODE_NORMAL && cnt_eff >= KEEP_C)
        |=> (mode_q == MODE_NORMAL && abort_q == $past(abort_q)));

    // R6: a normal frame aborted inside the window enters power-down
    a_r6_pd_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (end_frame && mode_q == MODE_NORMAL && cnt_eff >= PD_C && cnt_eff < KEEP_C)
        |=> (mode_q == MODE_PD));

    // R7: the abort counter only ever steps by one
    a_r7_abort_step: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_q == $past(abort_q)) || (abort_q == $past(abort_q) + ABORT_W'(1)));

    // R9: a dummy frame never touches the abort counter
    a_r9_wake_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_WAKE) |=> (abort_q == $past(abort_q)));
endmodule

// File: rtl/sar_bit_shifter.sv
// One core's output shifter: loads a framed word (leading zero, data,
// trailing zeros) or the all-ones dummy pattern, shifts MSB first on each
// counted falling edge and holds the drive-enable.
// Assumes: load, shift and kill come from sar_frame_ctrl; load is never
// asserted together with shift or kill.
module sar_bit_shifter #(
    parameter int DATA_W = 12,
    parameter int TAIL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              dummy_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic              shift_i,
    input  logic              kill_i,
    output logic              sdo_o,
    output logic              en_o
);
    localparam int SR_W = DATA_W + 1 + TAIL_W;

    logic [SR_W-1:0] sr_q;
    logic            en_q;

    // frame register and drive-enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
            en_q <= 1'b0;
        end else if (load_i) begin
            sr_q <= dummy_i ? {SR_W{1'b1}} : {1'b0, word_i, {TAIL_W{1'b0}}};
            en_q <= 1'b1;
        end else begin
            if (shift_i) sr_q <= {sr_q[SR_W-2:0], 1'b0};
            if (kill_i)  en_q <= 1'b0;
        end
    end

    assign sdo_o = en_q & sr_q[SR_W-1];
    assign en_o  = en_q;

    // R2: a chip-select fall always starts driving on the next cycle
    a_r2_load_drives: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> en_q);

    // R4: while released the data output reads 0
    a_r4_quiet_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !sdo_o);
endmodule

// File: rtl/sar_link_responder.sv
// Top of the dual-core serial responder: synchronizes the serial inputs,
// picks each core's sample through the registered channel choice and
// drives both serial outputs from one shared frame controller.
// Assumes: clk runs at least eight times faster than the serial clock.
module sar_link_responder
    import sar_link_pkg::*;
#(
    parameter int DATA_W   = 12,
    parameter int TAIL_W   = 2,
    parameter int PD_MIN   = 2,
    parameter int KEEP_MIN = 10,
    parameter int ABORT_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               cs_n,
    input  logic               chan_sel,
    input  logic [DATA_W-1:0]  a_in1,
    input  logic [DATA_W-1:0]  a_in2,
    input  logic [DATA_W-1:0]  b_in1,
    input  logic [DATA_W-1:0]  b_in2,
    output logic               dout_a,
    output logic               dout_b,
    output logic               dout_en,
    output logic [1:0]         mode_o,
    output logic [ABORT_W-1:0] abort_cnt_o
);
    localparam int NCORE = 2;
    localparam int NSYNC = 3;

    logic [NSYNC-1:0] s_lvl, s_rise, s_fall;
    logic             load, dummy, shift, kill, chan;
    link_mode_e       mode;
    logic [DATA_W-1:0] in1_v [NCORE];
    logic [DATA_W-1:0] in2_v [NCORE];
    logic [NCORE-1:0]  sdo_v, en_v;

    // bit 0 serial clock, bit 1 chip-select, bit 2 channel select
    sar_edge_sync #(.W(NSYNC), .STAGES(2), .RST_VAL(3'b011)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({chan_sel, cs_n, sclk}),
        .lvl_o  (s_lvl),
        .rise_o (s_rise),
        .fall_o (s_fall)
    );

    sar_frame_ctrl #(
        .DATA_W(DATA_W), .TAIL_W(TAIL_W), .PD_MIN(PD_MIN),
        .KEEP_MIN(KEEP_MIN), .ABORT_W(ABORT_W)
    ) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_fall_i   (s_fall[1]),
        .cs_rise_i   (s_rise[1]),
        .sck_fall_i  (s_fall[0]),
        .chsel_i     (s_lvl[2]),
        .load_o      (load),
        .dummy_o     (dummy),
        .shift_o     (shift),
        .kill_o      (kill),
        .chan_o      (chan),
        .mode_o      (mode),
        .abort_cnt_o (abort_cnt_o)
    );

    assign in1_v[0] = a_in1;
    assign in1_v[1] = b_in1;
    assign in2_v[0] = a_in2;
    assign in2_v[1] = b_in2;

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        logic [DATA_W-1:0] word;
        assign word = chan ? in2_v[c] : in1_v[c];

        sar_bit_shifter #(.DATA_W(DATA_W), .TAIL_W(TAIL_W)) i_shift (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (load),
            .dummy_i (dummy),
            .word_i  (word),
            .shift_i (shift),
            .kill_i  (kill),
            .sdo_o   (sdo_v[c]),
            .en_o    (en_v[c])
        );
    end

    assign dout_a  = sdo_v[0];
    assign dout_b  = sdo_v[1];
    assign dout_en = en_v[0];
    assign mode_o  = mode;

    // R11: both cores are driven and released together
    a_r11_cores_in_step: assert property (@(posedge clk) disable iff (!rst_n)
        en_v[0] == en_v[1]);

    // R6: in power-down the outputs are released
    a_r6_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PD) |-> !dout_en);
endmodule

// File: tb/test_sar_link_responder.sv
// Directed bench for sar_link_responder: each scenario is one call of the
// frame task, which checks every slot and the state after chip-select rises.
module test_sar_link_responder;
    localparam int DW   = 12;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1;
    logic cs_n = 1'b1;
    logic chan_sel = 1'b0;
    logic [DW-1:0] a_in1 = 12'hA5C, a_in2 = 12'h5A3;
    logic [DW-1:0] b_in1 = 12'h3F1, b_in2 = 12'hC0E;
    logic dout_a, dout_b, dout_en;
    logic [1:0] mode_o;
    logic [7:0] abort_cnt_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int mode_m  = 0;
    int ch_m    = 0;
    int abort_m = 0;

    always #2.5 clk = ~clk;

    sar_link_responder i_sar_link_responder (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .chan_sel(chan_sel),
        .a_in1(a_in1), .a_in2(a_in2), .b_in1(b_in1), .b_in2(b_in2),
        .dout_a(dout_a), .dout_b(dout_b), .dout_en(dout_en),
        .mode_o(mode_o), .abort_cnt_o(abort_cnt_o)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_bit(input int k, input logic [DW-1:0] w, input bit dmy);
        if (k >= 15) return 0;
        if (dmy) return 1;
        if (k >= 1 && k <= 12) return int'(w[12-k]);
        return 0;
    endfunction

    task automatic check_slot(input int k, input logic [DW-1:0] wa,
                              input logic [DW-1:0] wb, input bit dmy);
        string req;
        req = (k >= 15) ? "R4" : (dmy ? "R8" : "R2 R3");
        check(req, $sformatf("enable slot %0d", k), int'(dout_en), (k < 15) ? 1 : 0);
        check(req, $sformatf("dout_a slot %0d", k), int'(dout_a), exp_bit(k, wa, dmy));
        check(req, $sformatf("dout_b slot %0d", k), int'(dout_b), exp_bit(k, wb, dmy));
    endtask

    // one frame of n falling edges; simul puts the last edge with the rise
    task automatic run_frame(input int n, input bit sel, input bit simul, input string tag);
        bit dmy;
        logic [DW-1:0] wa, wb;
        int en_x, mode_x;
        dmy = (mode_m == 1);
        wa  = (ch_m == 1) ? a_in2 : a_in1;
        wb  = (ch_m == 1) ? b_in2 : b_in1;
        chan_sel = sel;
        cs_n = 1'b0;
        tick(HALF);
        check(dmy ? "R8" : "R2", "mode in frame", int'(mode_o), dmy ? 2 : mode_m);
        check_slot(0, wa, wb, dmy);
        for (int k = 1; k <= n; k++) begin
            if (simul && k == n) begin
                sclk = 1'b0;
                cs_n = 1'b1;
            end else begin
                sclk = 1'b0;
                tick(HALF);
                check_slot(k, wa, wb, dmy);
                sclk = 1'b1;
                tick(HALF);
            end
        end
        if (!simul) cs_n = 1'b1;
        tick(HALF);
        if (simul) begin
            sclk = 1'b1;
            tick(HALF);
        end
        if (n >= 2) ch_m = sel;
        if (dmy) begin
            mode_x = (n >= 10) ? 0 : 1;
        end else begin
            mode_x = (n < 2) ? mode_m : ((n < 10) ? 1 : 0);
            if (n < 10) abort_m++;
        end
        mode_m = mode_x;
        en_x = (n >= 10 && n < 15) ? 1 : 0;
        check(tag, "mode after frame", int'(mode_o), mode_m);
        check(tag, "abort count", int'(abort_cnt_o), abort_m);
        check(tag, "enable after frame", int'(dout_en), en_x);
        check(tag, "dout_a after frame", int'(dout_a), en_x ? exp_bit(n, wa, dmy) : 0);
        check(tag, "dout_b after frame", int'(dout_b), en_x ? exp_bit(n, wb, dmy) : 0);
        tick(HALF);
    endtask

    // serial clock toggles with chip-select high must leave outputs alone
    task automatic idle_clocks(input string tag);
        int en0, a0, b0;
        en0 = dout_en; a0 = dout_a; b0 = dout_b;
        for (int i = 0; i < 4; i++) begin
            sclk = 1'b0; tick(HALF);
            sclk = 1'b1; tick(HALF);
        end
        check(tag, "idle enable", int'(dout_en), en0);
        check(tag, "idle dout_a", int'(dout_a), a0);
        check(tag, "idle dout_b", int'(dout_b), b0);
        check(tag, "idle mode", int'(mode_o), mode_m);
    endtask

    task automatic reset_check();
        rst_n = 1'b0;
        tick(6);
        rst_n = 1'b1;
        tick(4);
        check("R1", "reset mode", int'(mode_o), 0);
        check("R1", "reset enable", int'(dout_en), 0);
        check("R1", "reset data", int'(dout_a | dout_b), 0);
        check("R1", "reset abort count", int'(abort_cnt_o), 0);
    endtask

    initial begin
        reset_check();
        run_frame(16, 1'b1, 1'b0, "R4");          // ch1 words, full frame
        idle_clocks("R4");
        run_frame(14, 1'b0, 1'b0, "R5");          // ch2 words, 14-clock framing
        run_frame(16, 1'b0, 1'b0, "R5");          // back-to-back after 14 clocks
        run_frame(5,  1'b1, 1'b0, "R6");          // abort into power-down
        idle_clocks("R6");
        run_frame(12, 1'b1, 1'b0, "R8 R9");       // dummy frame, wakes up
        run_frame(16, 1'b0, 1'b0, "R9");          // first valid frame after wake
        run_frame(1,  1'b1, 1'b0, "R7");          // early abort, select kept
        run_frame(16, 1'b1, 1'b0, "R3");          // still input 1
        run_frame(3,  1'b0, 1'b0, "R6");
        run_frame(6,  1'b0, 1'b0, "R9");          // dummy too short
        run_frame(10, 1'b1, 1'b0, "R9");          // dummy of exactly 10
        run_frame(16, 1'b1, 1'b0, "R3");          // input 2 selected
        run_frame(10, 1'b0, 1'b1, "R10");         // 10th edge with the rise
        run_frame(9,  1'b0, 1'b1, "R10");         // 9th edge with the rise
        run_frame(10, 1'b0, 1'b0, "R8");
        run_frame(0,  1'b0, 1'b0, "R7");          // pulse with no edges
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule